// File: doc/BRIEF.md
# DMA Channel Enable and Structure-Select Register Bank

This block keeps two per-channel state vectors for a multi-channel DMA controller. One vector is the channel enable. The other selects whether each channel uses its primary or its alternate control structure. Software never writes either vector directly. Each vector has one address where writing a 1 sets the matching bits and a second address where writing a 1 clears them. A 0 bit in the write data leaves the matching channel unchanged, so software can change one channel without a read-modify-write.

The transfer engine drives three per-channel event inputs. The first clears a channel's enable when its transfer cycle finishes. The second moves a channel to its alternate structure, and the third moves it back to the primary structure, which lets the engine alternate between the two during ping-pong or scatter-gather work. Software and hardware updates are merged under one rule: for any bit, a clear from any source beats a set from any source in the same cycle. Both vectors are also brought out as ports for the channel arbiter and the descriptor fetch logic.

Top module: `dma_chan_ctl_bank`

## Requirements
- R1: While reset is asserted, and after it is released, `ch_enable`, `ch_use_alt` and `bus_rdata` are all zero. Every channel therefore starts disabled and on its primary structure.
- R2: A write to offset 0x028 sets enable bit n on the next clock edge for every bit n that is 1 in `bus_wdata`. Bits written as 0 keep their value.
- R3: A write to offset 0x02C clears enable bit n on the next clock edge for every bit n that is 1 in `bus_wdata`. Bits written as 0 keep their value.
- R4: `hw_done[n]` high clears enable bit n on the next clock edge.
- R5: A write to offset 0x030 sets the alternate-select bits given by the 1s in `bus_wdata`. A write to offset 0x034 clears them. In both cases bits written as 0 are unchanged. A value of 1 means the channel uses its alternate structure, and 0 means its primary structure.
- R6: `hw_to_alt[n]` sets alternate-select bit n on the next edge. `hw_to_pri[n]` clears it on the next edge.
- R7: When a set and a clear target the same bit in the same cycle, the bit ends up 0. This applies to every combination of software and hardware sources.
- R8: A read of offset 0x028 returns the enable vector and a read of offset 0x030 returns the alternate-select vector, with bit 0 mapped to channel 0. The data appears on `bus_rdata` one cycle after `bus_rd` is sampled high. It is the state from before any write made in the same cycle.
- R9: A read of the write-only offsets 0x02C and 0x034, or of any unmapped offset, returns zero.
- R10: `bus_rdata` holds its last value in every cycle that follows a cycle with `bus_rd` low.
- R11: A write to an unmapped offset changes neither vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| hw_done | input | 32 | Per-channel cycle-complete pulse; clears the enable bit |
| hw_to_alt | input | 32 | Per-channel request to select the alternate structure |
| hw_to_pri | input | 32 | Per-channel request to select the primary structure |
| ch_enable | output | 32 | Current enable vector |
| ch_use_alt | output | 32 | Current alternate-select vector |

## Verification
A wrong state bit shows up on `ch_enable` or `ch_use_alt` one clock edge after the update that caused it. It shows up on `bus_rdata` one cycle after a read of that vector, so the bench checks both vectors after every operation. The collision cases are driven on purpose, because a wrong priority between set and clear changes only a single bit, and only in the cycle of the collision. Two other faults do not appear in the vectors at all: a read-data path that changes when no read is issued, and a write-only offset that returns data. Both are seen only on `bus_rdata`, so the bench targets them with dedicated reads.

// File: rtl/dma_bank_pkg.sv
package dma_bank_pkg;
  // Register byte offsets
  localparam int unsigned OFS_EN_SET  = 32'h28;
  localparam int unsigned OFS_EN_CLR  = 32'h2C;
  localparam int unsigned OFS_ALT_SET = 32'h30;
  localparam int unsigned OFS_ALT_CLR = 32'h34;

  // Read source select
  typedef enum logic [1:0] {
    RSEL_ZERO = 2'd0,
    RSEL_EN   = 2'd1,
    RSEL_ALT  = 2'd2
  } rsel_e;
endpackage

// File: rtl/dma_bank_decode.sv
module dma_bank_decode
  import dma_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              wr_en_set,
  output logic              wr_en_clr,
  output logic              wr_alt_set,
  output logic              wr_alt_clr,
  output rsel_e             rsel
);
  logic hit_en_set, hit_en_clr, hit_alt_set, hit_alt_clr;

  always_comb begin
    hit_en_set  = (addr == ADDR_W'(OFS_EN_SET));
    hit_en_clr  = (addr == ADDR_W'(OFS_EN_CLR));
    hit_alt_set = (addr == ADDR_W'(OFS_ALT_SET));
    hit_alt_clr = (addr == ADDR_W'(OFS_ALT_CLR));

    wr_en_set  = wr & hit_en_set;
    wr_en_clr  = wr & hit_en_clr;
    wr_alt_set = wr & hit_alt_set;
    wr_alt_clr = wr & hit_alt_clr;

    // Only the two set offsets return data; clear offsets are write-only
    if (hit_en_set)       rsel = RSEL_EN;
    else if (hit_alt_set) rsel = RSEL_ALT;
    else                  rsel = RSEL_ZERO;
  end
endmodule

// File: rtl/dma_setclr_vec.sv
module dma_setclr_vec #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic         upd;

  // Clear dominates set on the same bit
  always_comb begin
    q_d = (q_q | set_i) & ~clr_i;
    upd = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_q <= '0;
    else if (upd) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dma_bank_rdmux.sv
module dma_bank_rdmux
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  rsel_e             rsel,
  input  logic [NUM_CH-1:0] en_vec,
  input  logic [NUM_CH-1:0] alt_vec,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    case (rsel)
      RSEL_EN:  rdata_d[NUM_CH-1:0] = en_vec;
      RSEL_ALT: rdata_d[NUM_CH-1:0] = alt_vec;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dma_chan_ctl_bank.sv
module dma_chan_ctl_bank
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] hw_done,
  input  logic [NUM_CH-1:0] hw_to_alt,
  input  logic [NUM_CH-1:0] hw_to_pri,
  output logic [NUM_CH-1:0] ch_enable,
  output logic [NUM_CH-1:0] ch_use_alt
);
  logic              wr_en_set, wr_en_clr, wr_alt_set, wr_alt_clr;
  rsel_e             rsel;
  logic [NUM_CH-1:0] wbits;
  logic [NUM_CH-1:0] en_set, en_clr, alt_set, alt_clr;

  dma_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr       (bus_addr),
    .wr         (bus_wr),
    .wr_en_set  (wr_en_set),
    .wr_en_clr  (wr_en_clr),
    .wr_alt_set (wr_alt_set),
    .wr_alt_clr (wr_alt_clr),
    .rsel       (rsel)
  );

  // Merge software strobes with hardware events
  always_comb begin
    wbits   = bus_wdata[NUM_CH-1:0];
    en_set  = {NUM_CH{wr_en_set}}  & wbits;
    en_clr  = ({NUM_CH{wr_en_clr}}  & wbits) | hw_done;
    alt_set = ({NUM_CH{wr_alt_set}} & wbits) | hw_to_alt;
    alt_clr = ({NUM_CH{wr_alt_clr}} & wbits) | hw_to_pri;
  end

  dma_setclr_vec #(.W(NUM_CH)) u_en_vec (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (en_set),
    .clr_i (en_clr),
    .q_o   (ch_enable)
  );

  dma_setclr_vec #(.W(NUM_CH)) u_alt_vec (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (alt_set),
    .clr_i (alt_clr),
    .q_o   (ch_use_alt)
  );

  dma_bank_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (bus_rd),
    .rsel    (rsel),
    .en_vec  (ch_enable),
    .alt_vec (ch_use_alt),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/dma_chan_ctl_bank_chk.sv
module dma_chan_ctl_bank_chk
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] hw_done,
  input logic [NUM_CH-1:0] hw_to_alt,
  input logic [NUM_CH-1:0] hw_to_pri,
  input logic [NUM_CH-1:0] ch_enable,
  input logic [NUM_CH-1:0] ch_use_alt
);
  logic wr_en_any, wr_en_s, wr_en_c, rd_wo, wr_unmapped;
  assign wr_en_s   = bus_wr && (bus_addr == ADDR_W'(OFS_EN_SET));
  assign wr_en_c   = bus_wr && (bus_addr == ADDR_W'(OFS_EN_CLR));
  assign wr_en_any = wr_en_s || wr_en_c;
  assign rd_wo     = bus_rd && ((bus_addr == ADDR_W'(OFS_EN_CLR)) ||
                                (bus_addr == ADDR_W'(OFS_ALT_CLR)));
  assign wr_unmapped = bus_wr && (bus_addr != ADDR_W'(OFS_EN_SET)) &&
                       (bus_addr != ADDR_W'(OFS_EN_CLR)) &&
                       (bus_addr != ADDR_W'(OFS_ALT_SET)) &&
                       (bus_addr != ADDR_W'(OFS_ALT_CLR));

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (ch_enable == '0 && ch_use_alt == '0 && bus_rdata == '0));

  a_r2_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_s |=> ((ch_enable & $past(bus_wdata[NUM_CH-1:0]) & ~$past(hw_done)) ==
                 ($past(bus_wdata[NUM_CH-1:0]) & ~$past(hw_done))));

  a_r3_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_c |=> ((ch_enable & $past(bus_wdata[NUM_CH-1:0])) == '0));

  a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_done) |=> ((ch_enable & $past(hw_done)) == '0));

  a_r6_pri_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_to_pri) |=> ((ch_use_alt & $past(hw_to_pri)) == '0));

  a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wo |=> (bus_rdata == '0));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  a_r11_unmapped_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unmapped && hw_done == '0 && hw_to_alt == '0 && hw_to_pri == '0)
      |=> ($stable(ch_enable) && $stable(ch_use_alt)));

  a_r2_en_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_any && hw_done == '0) |=> $stable(ch_enable));
endmodule

bind dma_chan_ctl_bank dma_chan_ctl_bank_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .hw_done(hw_done), .hw_to_alt(hw_to_alt), .hw_to_pri(hw_to_pri),
  .ch_enable(ch_enable), .ch_use_alt(ch_use_alt)
);

// File: tb/dma_chan_ctl_bank_tb_top.sv
`timescale 1ns/1ps
module dma_chan_ctl_bank_tb_top;
  localparam logic [7:0] A_ES = 8'h28, A_EC = 8'h2C, A_AS = 8'h30, A_AC = 8'h34;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] hw_done, hw_to_alt, hw_to_pri, ch_enable, ch_use_alt;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_en = '0, m_alt = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;
  logic [31:0] held;

  always #2.5 clk = ~clk;

  dma_chan_ctl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hw_done(hw_done), .hw_to_alt(hw_to_alt), .hw_to_pri(hw_to_pri),
    .ch_enable(ch_enable), .ch_use_alt(ch_use_alt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at the next falling edge
  task automatic op(input logic wr, input logic rd, input logic [7:0] a,
                    input logic [31:0] wd, input logic [31:0] dn,
                    input logic [31:0] ta, input logic [31:0] tp, input string tag);
    logic [31:0] es, ec, as_, ac;
    es  = (wr && a == A_ES) ? wd : '0;
    ec  = ((wr && a == A_EC) ? wd : '0) | dn;
    as_ = ((wr && a == A_AS) ? wd : '0) | ta;
    ac  = ((wr && a == A_AC) ? wd : '0) | tp;
    if (rd) begin
      exp_q.push_back(a == A_ES ? m_en : (a == A_AS ? m_alt : 32'h0));
      tag_q.push_back(tag);
    end
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    hw_done = dn; hw_to_alt = ta; hw_to_pri = tp;
    @(posedge clk);
    m_en  = (m_en  | es)  & ~ec;
    m_alt = (m_alt | as_) & ~ac;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    hw_done = '0; hw_to_alt = '0; hw_to_pri = '0;
  endtask

  task automatic wr_(input logic [7:0] a, input logic [31:0] d, input string t);
    op(1, 0, a, d, '0, '0, '0, t);
  endtask
  task automatic rd_(input logic [7:0] a, input string t);
    op(0, 1, a, '0, '0, '0, '0, t);
  endtask
  task automatic hw(input logic [31:0] dn, input logic [31:0] ta, input logic [31:0] tp, input string t);
    op(0, 0, 8'h00, '0, dn, ta, tp, t);
  endtask

  // Monitor: scoreboard for reads plus state comparison
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rd_d) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R8: actual unexpected read expected none");
        end else
          check({tag_q.pop_front(), " read data"}, bus_rdata, exp_q.pop_front());
      end
      check("R2/R3/R4/R7 enable vector", ch_enable, m_en);
      check("R5/R6/R7 alternate vector", ch_use_alt, m_alt);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    hw_done = '0; hw_to_alt = '0; hw_to_pri = '0;
    repeat (3) @(negedge clk);
    check("R1 reset enable", ch_enable, 32'h0);
    check("R1 reset alt", ch_use_alt, 32'h0);
    check("R1 reset rdata", bus_rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);
    rd_(A_ES, "R1 enable after reset");

    wr_(A_ES, 32'h0000_0005, "R2");
    check("R2 set bits 0,2", ch_enable, 32'h0000_0005);
    wr_(A_ES, 32'h0, "R2");
    check("R2 zero write no effect", ch_enable, 32'h0000_0005);
    wr_(A_ES, 32'h8000_0000, "R2");
    rd_(A_ES, "R8 enable read");
    check("R2 set bit 31", ch_enable, 32'h8000_0005);

    wr_(A_EC, 32'h0000_0001, "R3");
    check("R3 clear bit 0", ch_enable, 32'h8000_0004);
    wr_(A_EC, 32'h0, "R3");
    check("R3 zero clear no effect", ch_enable, 32'h8000_0004);
    rd_(A_EC, "R9 enable-clear read");

    hw(32'h0000_0004, '0, '0, "R4");
    check("R4 done clears bit 2", ch_enable, 32'h8000_0000);

    op(1, 0, A_ES, 32'h0000_000F, 32'h0000_0002, '0, '0, "R7");
    check("R7 done beats sw set", ch_enable, 32'h8000_000D);

    wr_(A_AS, 32'h0000_00F0, "R5");
    rd_(A_AS, "R8 alt read");
    check("R5 alt set", ch_use_alt, 32'h0000_00F0);
    wr_(A_AC, 32'h0000_0010, "R5");
    check("R5 alt clear", ch_use_alt, 32'h0000_00E0);
    rd_(A_AC, "R9 alt-clear read");

    hw('0, 32'h0000_0003, '0, "R6");
    check("R6 hw to alt", ch_use_alt, 32'h0000_00E3);
    hw('0, '0, 32'h0000_0080, "R6");
    check("R6 hw to primary", ch_use_alt, 32'h0000_0063);

    op(1, 0, A_AS, 32'h0000_0100, '0, '0, 32'h0000_0100, "R7");
    check("R7 pri beats sw alt set", ch_use_alt, 32'h0000_0063);
    hw('0, 32'h0000_0004, 32'h0000_0004, "R7");
    check("R7 pri beats hw alt", ch_use_alt, 32'h0000_0063);
    op(1, 0, A_AC, 32'h0000_0001, '0, 32'h0000_0009, '0, "R7");
    check("R7 sw alt clear beats hw alt", ch_use_alt, 32'h0000_006A);

    wr_(8'h40, 32'hFFFF_FFFF, "R11");
    wr_(8'h00, 32'hFFFF_FFFF, "R11");
    check("R11 unmapped enable", ch_enable, 32'h8000_000D);
    check("R11 unmapped alt", ch_use_alt, 32'h0000_006A);
    rd_(8'h40, "R9 unmapped read");

    op(1, 1, A_ES, 32'h0000_0010, '0, '0, '0, "R8 read-with-write");
    check("R8 write in read cycle applied", ch_enable, 32'h8000_001D);
    rd_(A_ES, "R8 enable after write");

    held = bus_rdata;
    wr_(A_ES, 32'h0000_0100, "R10");
    hw('0, 32'h0000_1000, '0, "R10");
    check("R10 rdata held", bus_rdata, held);
    check("R10 rdata value", held, 32'h8000_001D);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule